// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short record of how the most recently resolved branches went, as one global outcome history. A branch's prediction comes from a saturating counter, and that counter is chosen by two things together: a few low address bits of the branch, and the current contents of that history. Because the history takes part in the choice, the predictor can learn a branch whose direction depends on what nearby branches just did. A predictor that looks only at a branch's own address cannot learn that.

A fetch stage presents a PC on the lookup port. One cycle later it receives a taken or not-taken guess, together with the history value that was used to make it. When the branch resolves, the execute stage sends back the PC, the actual outcome and that same history value. The block then trains the one counter that made the guess and shifts the outcome into the global history. The history length, the counter width, the number of address-selected rows and the count of dropped alignment bits are all parameters.

Top module: `corr_bpred`

## Requirements
- R1: After a synchronous reset, the global history is zero, every counter holds zero (strongly not taken) and pred_valid is low.
- R2: A lookup in cycle t produces pred_valid, pred_taken and pred_hist on the following cycle. pred_hist equals the global history as it was in cycle t.
- R3: An update with outcome taken raises the selected counter by one. At its maximum value (all ones) the counter stays at the maximum and does not wrap.
- R4: An update with outcome not taken lowers the selected counter by one. At zero the counter stays at zero and does not wrap.
- R5: The prediction is taken exactly when the top bit of the selected counter is set. For 2-bit counters, values 2 and 3 predict taken and values 0 and 1 predict not taken.
- R6: Each update shifts its outcome (1 = taken) into history bit 0 and moves the older bits up one place, dropping the oldest. Without an update, the history holds its value.
- R7: An update changes only the counter selected by its address row and its upd_hist value. Every other counter keeps its value.
- R8: When a lookup and an update select the same counter in the same cycle, the prediction reflects the counter value from before the update. pred_hist likewise shows the history from before the shift.
- R9: The row is taken from PC bits [ALIGN+IDX_W-1:ALIGN]. PC bits above and below that field have no effect on which counter is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_valid | output | 1 | Prediction is present (one cycle after lk_valid) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Global history used for this prediction |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History value returned with the prediction |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The lookup port can only read counters selected by the live global history. A counter under any other history value cannot be observed until that history has been built up. To do this, the bench drives chosen outcomes through sacrificial updates on a spare row, which walks the history to any wanted value. Its model tracks the side effects of those updates. With this method, every counter of the small default configuration is swept after saturation runs in both directions. The same-cycle collision case is produced by raising lookup and update on one edge, with the counter set one step below the taken threshold.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } br_dir_e;
endpackage

// File: rtl/bpred_hist.sv
module bpred_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   widened;

  assign widened = {hist_q, shift_bit};

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= widened[HIST_W-1:0];
  end

  assign hist = hist_q;

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(shift_bit)); // R6
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !$past(rst)) |=> $stable(hist_q)); // R6
endmodule

// File: rtl/bpred_ctr_next.sv
module bpred_ctr_next #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             taken,
  output logic [CTR_W-1:0] nxt
);
  localparam logic [CTR_W-1:0] TOP  = '1;
  localparam logic [CTR_W-1:0] ZERO = '0;
  localparam logic [CTR_W-1:0] ONE  = CTR_W'(1);

  always_comb begin
    if (taken) nxt = (cur == TOP)  ? cur : cur + ONE;
    else       nxt = (cur == ZERO) ? cur : cur - ONE;
  end

  always_comb begin
    AST_NO_OVERFLOW: assert (!taken || nxt >= cur); // R3
    AST_NO_UNDERFLOW: assert (taken || nxt <= cur); // R4
  end
endmodule

// File: rtl/bpred_table.sv
module bpred_table #(
  parameter int ADDR_W = 4,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CTR_W-1:0]  rd_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [CTR_W-1:0]  wr_cur,
  input  logic [CTR_W-1:0]  wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign wr_cur = mem[wr_addr];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 2,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);
  import bpred_pkg::*;

  localparam int ADDR_W = IDX_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [CTR_W-1:0]  rd_q, wr_cur, wr_nxt;
  logic              pred_valid_q;
  logic [HIST_W-1:0] pred_hist_q;
  br_dir_e           outcome;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc, upd_pc};
  assign outcome = upd_taken ? DIR_TAKEN : DIR_NOT_TAKEN;
  assign rd_addr = {lk_pc[ALIGN +: IDX_W], ghist};
  assign wr_addr = {upd_pc[ALIGN +: IDX_W], upd_hist};

  bpred_hist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid),
    .shift_bit(outcome == DIR_TAKEN), .hist(ghist)
  );

  bpred_ctr_next #(.CTR_W(CTR_W)) u_next (
    .cur(wr_cur), .taken(outcome == DIR_TAKEN), .nxt(wr_nxt)
  );

  bpred_table #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(lk_valid), .rd_addr(rd_addr), .rd_q(rd_q),
    .wr_en(upd_valid), .wr_addr(wr_addr), .wr_cur(wr_cur), .wr_data(wr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid_q <= 1'b0;
      pred_hist_q  <= '0;
    end else begin
      pred_valid_q <= lk_valid;
      if (lk_valid) pred_hist_q <= ghist;
    end
  end

  assign pred_valid = pred_valid_q;
  assign pred_hist  = pred_hist_q;
  assign pred_taken = rd_q[CTR_W-1];

  AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R2
  AST_PRED_HIST: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_hist == $past(ghist)); // R2
endmodule

// File: tb/tb_corr_bpred.sv
module tb_corr_bpred;
  localparam int PC_W = 32, ALIGN = 2, IDX_W = 2, HIST_W = 2, CTR_W = 2;
  localparam int ROWS = 1 << IDX_W;
  localparam int HV   = 1 << HIST_W;
  localparam int CMAX = (1 << CTR_W) - 1;
  localparam int THR  = 1 << (CTR_W - 1);

  logic clk = 0, rst = 1;
  logic lk_valid = 0, upd_valid = 0, upd_taken = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic [HIST_W-1:0] upd_hist = '0;
  logic pred_valid, pred_taken;
  logic [HIST_W-1:0] pred_hist;

  int total = 0, bad = 0;
  int model [ROWS*HV];
  int ghr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  corr_bpred #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] mkpc(int row, int hi, int lo);
    return (PC_W'(hi) << (ALIGN + IDX_W)) | (PC_W'(row) << ALIGN) | PC_W'(lo & ((1 << ALIGN) - 1));
  endfunction

  function automatic void model_upd(int row, int h, int t);
    int e = row * HV + h;
    if (t != 0) begin if (model[e] < CMAX) model[e]++; end
    else begin if (model[e] > 0) model[e]--; end
    ghr = ((ghr << 1) | (t & 1)) & (HV - 1);
  endfunction

  task automatic update(logic [PC_W-1:0] pc, int h, int t);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_hist = HIST_W'(h); upd_taken = t[0];
    @(negedge clk);
    upd_valid = 0;
    model_upd(int'(pc[ALIGN +: IDX_W]), h, t);
  endtask

  task automatic lookup(logic [PC_W-1:0] pc, string req);
    int row = int'(pc[ALIGN +: IDX_W]);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 0;
    check(req, int'(pred_valid), 1);
    check(req, int'(pred_hist), ghr);
    check(req, int'(pred_taken), (model[row * HV + ghr] >= THR) ? 1 : 0);
  endtask

  // walk the global history to h using the spare row ROWS-1
  task automatic set_hist(int h);
    for (int b = HIST_W - 1; b >= 0; b--) update(mkpc(ROWS - 1, 0, 0), ghr, (h >> b) & 1);
  endtask

  task automatic sweep_all(string req);
    for (int h = 0; h < HV; h++)
      for (int r = 0; r < ROWS; r++) begin
        set_hist(h);
        lookup(mkpc(r, 0, 0), req);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr = 32'h1234_5678;
    for (int k = 0; k < ROWS*HV; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 pred_valid", int'(pred_valid), 0);
    for (int r = 0; r < ROWS; r++) lookup(mkpc(r, 0, 0), "R1 R2 reset lookup");

    // R3 R5: count up under history 2 on row 1, past saturation
    for (int k = 0; k < CMAX + 2; k++) begin
      update(mkpc(1, 0, 0), 2, 1);
      set_hist(2);
      lookup(mkpc(1, 0, 0), "R3 R5 up");
    end
    // R4 R5: count down past zero
    for (int k = 0; k < CMAX + 2; k++) begin
      update(mkpc(1, 0, 0), 2, 0);
      set_hist(2);
      lookup(mkpc(1, 0, 0), "R4 R5 down");
    end

    // R7: train one counter, sweep every counter
    update(mkpc(2, 0, 0), 1, 1);
    update(mkpc(2, 0, 0), 1, 1);
    update(mkpc(2, 0, 0), 1, 1);
    sweep_all("R7 isolation");

    // R6: history shifting seen through pred_hist
    for (int k = 0; k < 6; k++) begin
      update(mkpc(0, 5, 0), ghr, (k * 5 + 1) % 3 == 0 ? 1 : 0);
      lookup(mkpc(0, 0, 0), "R6 history");
    end
    @(negedge clk); @(negedge clk);
    lookup(mkpc(0, 0, 0), "R6 hold");

    // R8: same-cycle collision, counter one below the threshold
    set_hist(3);
    while (model[0 * HV + 3] < THR - 1) update(mkpc(0, 0, 0), 3, 1);
    while (model[0 * HV + 3] > THR - 1) update(mkpc(0, 0, 0), 3, 0);
    set_hist(3);
    @(negedge clk);
    lk_valid = 1; lk_pc = mkpc(0, 0, 0);
    upd_valid = 1; upd_pc = mkpc(0, 0, 0); upd_hist = HIST_W'(3); upd_taken = 1;
    @(negedge clk);
    lk_valid = 0; upd_valid = 0;
    check("R8 old counter", int'(pred_taken), 0);
    check("R8 old history", int'(pred_hist), 3);
    model_upd(0, 3, 1);
    set_hist(3);
    lookup(mkpc(0, 0, 0), "R8 after");

    // R9: aliasing across upper and alignment bits
    set_hist(0);
    update(mkpc(1, 77, 3), 0, 1);
    update(mkpc(1, 12, 1), 0, 1);
    set_hist(0);
    lookup(mkpc(1, 999, 2), "R9 alias");
    check("R9 alias taken", int'(pred_taken), 1);

    // mixed sequence
    for (int k = 0; k < 400; k++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      if (lfsr[0]) update(mkpc(int'(lfsr[3:2]), int'(lfsr[15:8]), int'(lfsr[7:6])), ghr, int'(lfsr[4]));
      else lookup(mkpc(int'(lfsr[3:2]), int'(lfsr[15:8]), int'(lfsr[7:6])), "R2 R3 R4 R6 R7 mixed");
    end
    sweep_all("R7 final sweep");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule